// File: doc/BRIEF.md
# Pin Event GPIO Controller

This block is a 32-pin general-purpose I/O controller with a word-addressed register port. Software drives pins by writing an output value register and a per-pin drive-enable register. It reads back the levels actually present on the pads after a two-flop synchroniser. Each pin also has its own event detector. The detector can trigger on low level, high level, rising edge, falling edge, or on both edges.

Detected events set bits in a sticky event register. Software clears those bits by writing ones. An enable mask gates the event bits onto two interrupt lines: one line serves the lower half of the pins and the other serves the upper half. Register writes take effect at the next clock edge. Reads are combinational from the selected register.

Top module: `gpio_ev_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `pad_oe` and `pad_out` are zero and `irq` is zero.
- R2: `pad_oe` equals the drive-enable register (1 = pin driven) and `pad_out` equals the output value register, one edge after a write. A read of the output value register returns the last value written to it.
- R3: A read of the pad level register returns `pad_in` delayed by two clock edges.
- R4: The per-pin 2-bit trigger code is 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge. Pins 0 to 15 take their code from trigger word A at bits 2*pin+1:2*pin. Pins 16 to 31 take their code from trigger word B at bits 2*(pin-16)+1:2*(pin-16).
- R5: When a pin's bit in the dual-edge register is 1, that pin sets its event bit on every transition, and its 2-bit code is ignored.
- R6: An event bit stays set until software writes a 1 to it in the event register. Writing 0 to a bit leaves it unchanged.
- R7: `irq[0]` is 1 exactly when some pin in 0 to 15 has both its event bit and its mask bit set. `irq[1]` does the same for pins 16 to 31. A mask bit of 0 blocks that pin.
- R8: A level condition sets its event bit on every cycle it holds. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: Register byte offsets are: output value 0x00, drive-enable 0x04, pad level 0x08 (read only), trigger word A 0x0C, trigger word B 0x10, mask 0x14, event 0x18, dual-edge 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| pad_in | input | 32 | Levels present on the pads |
| pad_out | output | 32 | Values driven onto the pads |
| pad_oe | output | 32 | Per-pin drive enable |
| irq | output | 2 | Interrupt lines for the lower and upper pin halves |

## Verification
The pins are given a mix of modes in one configuration: one high-level pin, one rising-edge pin, one falling-edge pin, one low-level pin, and one dual-edge pin whose code would otherwise mean low level. A raising pad pattern and then a falling pad pattern tell the edge directions apart. They also show whether the dual-edge override works.

Clearing a bit while its level still holds separates event priority from plain clearing. A zero write and partial masks separate the write-one-to-clear rule and the half-split of the interrupt lines. A behavioural model is compared every clock against the outputs and against the event register.

// File: rtl/gpio_ev_pkg.sv
`timescale 1ns/1ps
package gpio_ev_pkg;
    localparam int NPIN   = 32;
    localparam int NLINE  = 2;
    localparam int PPL    = NPIN / NLINE;
    localparam int AW     = 5;
    localparam int CODE_W = 2;

    typedef enum logic [2:0] {
        IDX_DATA  = 3'd0,
        IDX_DIR   = 3'd1,
        IDX_PAD   = 3'd2,
        IDX_TRGA  = 3'd3,
        IDX_TRGB  = 3'd4,
        IDX_MASK  = 3'd5,
        IDX_EVT   = 3'd6,
        IDX_DUAL  = 3'd7
    } reg_idx_e;

    typedef enum logic [CODE_W-1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef struct packed {
        logic             wr;
        reg_idx_e         idx;
        logic [NPIN-1:0]  wdata;
    } bus_req_t;

    function automatic logic pin_event(trig_e t, logic dual, logic cur, logic prev);
        logic r;
        if (dual) begin
            r = cur ^ prev;
        end else begin
            case (t)
                TRIG_LOW:  r = ~cur;
                TRIG_HIGH: r = cur;
                TRIG_RISE: r = cur & ~prev;
                default:   r = ~cur & prev;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/gpio_ev_sync.sv
`timescale 1ns/1ps
module gpio_ev_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_cur,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q_cur  <= '0;
            q_prev <= '0;
        end else begin
            meta_q <= d_in;
            q_cur  <= meta_q;
            q_prev <= q_cur;
        end
    end
endmodule

// File: rtl/gpio_ev_detect.sv
`timescale 1ns/1ps
module gpio_ev_detect
    import gpio_ev_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic [N-1:0]          cur,
    input  logic [N-1:0]          prev,
    input  logic [N-1:0]          trg_a,
    input  logic [N-1:0]          trg_b,
    input  logic [N-1:0]          dual,
    output logic [N-1:0]          ev
);
    localparam int HALF = N / 2;

    for (genvar i = 0; i < N; i++) begin : g_pin
        trig_e code;
        if (i < HALF) begin : g_lo
            assign code = trig_e'(trg_a[CODE_W*i +: CODE_W]);
        end else begin : g_hi
            assign code = trig_e'(trg_b[CODE_W*(i-HALF) +: CODE_W]);
        end
        assign ev[i] = pin_event(code, dual[i], cur[i], prev[i]);
    end
endmodule

// File: rtl/gpio_ev_regs.sv
`timescale 1ns/1ps
module gpio_ev_regs
    import gpio_ev_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic [N-1:0]  ev,
    input  logic [N-1:0]  pad_lvl,
    output logic [N-1:0]  data_q,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  trga_q,
    output logic [N-1:0]  trgb_q,
    output logic [N-1:0]  mask_q,
    output logic [N-1:0]  evt_q,
    output logic [N-1:0]  dual_q,
    output logic [N-1:0]  rdata
);
    logic [N-1:0] clr;

    assign clr = (req.wr && req.idx == IDX_EVT) ? req.wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            trga_q <= '0;
            trgb_q <= '0;
            mask_q <= '0;
            dual_q <= '0;
            evt_q  <= '0;
        end else begin
            if (req.wr) begin
                case (req.idx)
                    IDX_DATA: data_q <= req.wdata;
                    IDX_DIR:  dir_q  <= req.wdata;
                    IDX_TRGA: trga_q <= req.wdata;
                    IDX_TRGB: trgb_q <= req.wdata;
                    IDX_MASK: mask_q <= req.wdata;
                    IDX_DUAL: dual_q <= req.wdata;
                    default: ;
                endcase
            end
            evt_q <= (evt_q & ~clr) | ev;
        end
    end

    always_comb begin
        case (req.idx)
            IDX_DATA: rdata = data_q;
            IDX_DIR:  rdata = dir_q;
            IDX_PAD:  rdata = pad_lvl;
            IDX_TRGA: rdata = trga_q;
            IDX_TRGB: rdata = trgb_q;
            IDX_MASK: rdata = mask_q;
            IDX_EVT:  rdata = evt_q;
            default:  rdata = dual_q;
        endcase
    end
endmodule

// File: rtl/gpio_ev_ctrl.sv
`timescale 1ns/1ps
module gpio_ev_ctrl
    import gpio_ev_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [NPIN-1:0]    reg_wdata,
    output logic [NPIN-1:0]    reg_rdata,
    input  logic [NPIN-1:0]    pad_in,
    output logic [NPIN-1:0]    pad_out,
    output logic [NPIN-1:0]    pad_oe,
    output logic [NLINE-1:0]   irq
);
    bus_req_t        req;
    logic            unused_lsb;
    logic [NPIN-1:0] lvl_cur, lvl_prev, ev;
    logic [NPIN-1:0] trga_q, trgb_q, mask_q, evt_q, dual_q;
    logic [NPIN-1:0] pending;

    assign unused_lsb = ^reg_addr[1:0];
    assign req.wr    = reg_wr;
    assign req.idx   = reg_idx_e'(reg_addr[AW-1:2]);
    assign req.wdata = reg_wdata;

    gpio_ev_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst(rst), .d_in(pad_in),
        .q_cur(lvl_cur), .q_prev(lvl_prev)
    );

    gpio_ev_detect #(.N(NPIN)) u_det (
        .cur(lvl_cur), .prev(lvl_prev), .trg_a(trga_q), .trg_b(trgb_q),
        .dual(dual_q), .ev(ev)
    );

    gpio_ev_regs #(.N(NPIN)) u_regs (
        .clk(clk), .rst(rst), .req(req), .ev(ev), .pad_lvl(lvl_cur),
        .data_q(pad_out), .dir_q(pad_oe), .trga_q(trga_q), .trgb_q(trgb_q),
        .mask_q(mask_q), .evt_q(evt_q), .dual_q(dual_q), .rdata(reg_rdata)
    );

    assign pending = evt_q & mask_q;

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        assign irq[l] = |pending[l*PPL +: PPL];
    end
endmodule

// File: rtl/gpio_ev_checker.sv
`timescale 1ns/1ps
module gpio_ev_checker
    import gpio_ev_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [NPIN-1:0]   reg_wdata,
    input logic [NPIN-1:0]   pad_in,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic [NLINE-1:0]  irq,
    input logic [NPIN-1:0]   evt,
    input logic [NPIN-1:0]   mask,
    input logic [NPIN-1:0]   lvl
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: outputs quiet while in reset
    always_ff @(posedge clk) begin
        if (rst) assert_reset_quiet_R1: assert (irq == '0 || $past(rst) == 1'b0);
    end

    // R2: drive enable and output value follow a write one edge later
    assert_dir_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[AW-1:2] == 3'd1) |=> (pad_oe == $past(reg_wdata)));
    assert_data_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[AW-1:2] == 3'd0) |=> (pad_out == $past(reg_wdata)));

    // R3: pad level is input delayed by two edges
    assert_pad_delay_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (lvl == $past(pad_in, 2)));

    // R6: event bits never drop without a clear write
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr[AW-1:2] == 3'd6) |=> ((evt & $past(evt)) == $past(evt)));

    // R7: masked-off pins never raise a line
    assert_mask_block_R7: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> (irq == '0));
    assert_line_lo_R7: assert property (@(posedge clk) disable iff (rst)
        ((evt[PPL-1:0] & mask[PPL-1:0]) != '0) |-> irq[0]);
endmodule

bind gpio_ev_ctrl gpio_ev_checker u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq), .evt(evt_q), .mask(mask_q), .lvl(lvl_cur)
);

// File: tb/test_gpio_ev_ctrl.sv
`timescale 1ns/100ps
module test_gpio_ev_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h18;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_ev_ctrl i_gpio_ev_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_reg [8];
    logic [31:0] m_s1, m_s2, m_prev;

    function automatic logic [31:0] m_read(logic [4:0] a);
        if (a[4:2] == 3'd2) return m_s2;
        return m_reg[a[4:2]];
    endfunction

    always @(posedge clk) begin
        logic [31:0] nev;
        if (rst) begin
            for (int k = 0; k < 8; k++) m_reg[k] <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
        end else begin
            nev = '0;
            for (int p = 0; p < 32; p++) begin
                int code;
                code = (p < 16) ? ((m_reg[3] >> (2*p)) & 3) : ((m_reg[4] >> (2*(p-16))) & 3);
                if (m_reg[7][p]) nev[p] = m_s2[p] != m_prev[p];
                else if (code == 0) nev[p] = !m_s2[p];
                else if (code == 1) nev[p] = m_s2[p];
                else if (code == 2) nev[p] = m_s2[p] && !m_prev[p];
                else nev[p] = !m_s2[p] && m_prev[p];
            end
            if (reg_wr && reg_addr[4:2] != 3'd2 && reg_addr[4:2] != 3'd6)
                m_reg[reg_addr[4:2]] <= reg_wdata;
            m_reg[6] <= (m_reg[6] & ~((reg_wr && reg_addr[4:2] == 3'd6) ? reg_wdata : 32'h0)) | nev;
            m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against model every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] pend;
            #0.1;
            pend = m_reg[6] & m_reg[5];
            check("R2 pad_oe model", pad_oe, m_reg[1]);
            check("R2 pad_out model", pad_out, m_reg[0]);
            check("R7 irq model", {30'h0, irq}, {30'h0, |pend[31:16], |pend[15:0]});
            check("R6 rdata model", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 5'h18;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp);
        #0.5;
        reg_addr = 5'h18;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: before any post-reset edge all registers read zero
        for (int a = 0; a < 8; a++) begin
            reg_addr = 5'(a * 4);
            #0.2;
            check("R1 reset reg", reg_rdata, 32'h0);
        end
        reg_addr = 5'h18;
        check("R1 reset oe/out", pad_oe | pad_out, 32'h0);
        check("R1 reset irq", {30'h0, irq}, 32'h0);

        // default code 0 = low level: pads low set all bits, masked
        idle(4);
        rd(5'h18, 32'hFFFF_FFFF, "R4 default low level");
        check("R7 masked", {30'h0, irq}, 32'h0);

        // R9 layout and mode programming
        wr(5'h0C, 32'h5555_1955);
        wr(5'h10, 32'h4555_5755);
        wr(5'h1C, 32'h0000_0080);
        rd(5'h0C, 32'h5555_1955, "R9 trigger A readback");
        rd(5'h10, 32'h4555_5755, "R9 trigger B readback");
        rd(5'h1C, 32'h0000_0080, "R9 dual readback");
        wr(5'h18, 32'hFFFF_FFFF);
        idle(1);
        // pin 30 low level wins over clear; pin 7 dual overrides code 0
        rd(5'h18, 32'h4000_0000, "R8 event beats clear / R5 override");
        wr(5'h14, 32'hFFFF_FFFF);
        check("R7 upper line only", {30'h0, irq}, 32'h2);

        pad_in = 32'h4000_0000;
        idle(4);
        wr(5'h18, 32'h4000_0000);
        rd(5'h18, 32'h0, "R6 cleared");
        check("R7 idle lines", {30'h0, irq}, 32'h0);

        // raising pattern: pin3 high, pin5 rise, pin7 dual, pin20 fall
        pad_in = 32'h4010_00A8;
        idle(4);
        rd(5'h18, 32'h0000_00A8, "R4 rise/high R5 dual");
        rd(5'h08, 32'h4010_00A8, "R3 pad level");
        check("R7 lower line", {30'h0, irq}, 32'h1);
        wr(5'h18, 32'h0000_00A8);
        rd(5'h18, 32'h0000_0008, "R8 level re-sets");

        // falling pattern
        pad_in = 32'h4000_0000;
        idle(4);
        rd(5'h18, 32'h0010_0088, "R4 fall R5 dual");
        check("R7 both lines", {30'h0, irq}, 32'h3);
        wr(5'h18, 32'h0);
        rd(5'h18, 32'h0010_0088, "R6 zero write no effect");
        wr(5'h14, 32'h0000_FFFF);
        check("R7 half mask", {30'h0, irq}, 32'h1);
        wr(5'h14, 32'h0);
        check("R7 full mask", {30'h0, irq}, 32'h0);

        // R2 drive path
        wr(5'h00, 32'hDEAD_BEEF);
        wr(5'h04, 32'h0000_FFFF);
        check("R2 pad_out", pad_out, 32'hDEAD_BEEF);
        check("R2 pad_oe", pad_oe, 32'h0000_FFFF);
        rd(5'h00, 32'hDEAD_BEEF, "R2 data readback");

        // R3 latency
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(negedge clk);
        reg_addr = 5'h08; #0.5;
        check("R3 after one edge", reg_rdata, 32'h4000_0000);
        @(negedge clk); #0.5;
        check("R3 after two edges", reg_rdata, 32'h1234_5678);
        reg_addr = 5'h18;
        idle(4);
        finish_run();
    end
endmodule